// File: doc/BRIEF.md
# Windowed State Precedence Checker

This block watches two interval-states of a design, here called the lead state and the follow state. Each state is reported to the checker as a pair of single-cycle pulses: one marks the cycle the state begins and one marks the cycle it ends. A separate tick-enable input defines the unit in which delays are measured. When the lead state ends, the checker arms itself and counts ticks. It then demands that the follow state begin after no fewer than `MIN_TICKS` and no more than `MAX_TICKS` ticks. If that demand is broken, a sticky violation flag is raised and stays high until reset.

A bound of zero leaves that side of the window open. `[0,n]` means the follow state must begin within n ticks. `[m,0]` means at least m ticks with no limit above. `[m,m]` means exactly m ticks. The tick in the cycle where the follow state begins is counted, and the tick in the cycle where the lead state ends is not. Once the follow state begins correctly, the checker disarms and ignores ticks until the lead state ends again. Turning design signals into the four event pulses is done by a separate adapter.

The control automaton has five states. Four come from the activity of the two states: `ST_IDLE` (neither active), `ST_A_ON` (lead only), `ST_B_ON` (follow only) and `ST_BOTH` (both active). The fifth is the absorbing `ST_FAIL`. Among the four activity states, each begin pulse moves to the state in which that interval is active, and each end pulse moves to the state in which it is inactive. Any detected fault, in any activity state, moves the automaton to `ST_FAIL`, which it never leaves except through reset.

Top module: `wprec_checker`

## Requirements
- R1: A synchronous reset clears the automaton, the arming flag and the tick counter, and `violation_o` is 0 in the cycle after reset is released.
- R2: Begin and end pulses of each state must alternate. A begin while that state is active, an end while it is inactive, or a begin and end of the same state in one cycle each raise `violation_o` in the next cycle.
- R3: A follow-state begin while the checker is not armed raises a violation. This covers a follow begin with no lead end before it, and a follow begin while the lead state is still active. A lead end in the same cycle is the exception (see R12).
- R4: While armed, each cycle with `tick_i` high adds one to the gap count. The tick in the cycle of the follow begin is included, and the tick in the cycle of the lead end is excluded. A follow begin whose gap lies inside the window causes no violation.
- R5: A follow begin with a gap below `MIN_TICKS` raises a violation.
- R6: With `MAX_TICKS` nonzero, a tick that would make the gap exceed `MAX_TICKS` while armed raises a violation. This holds even if the follow state begins in that same cycle.
- R7: With `MAX_TICKS` = 0 there is no upper bound. The gap count saturates rather than wrapping, so very long gaps still meet the minimum.
- R8: With `MIN_TICKS` = `MAX_TICKS` = m, only a gap of exactly m ticks is legal.
- R9: After a correct follow begin the checker is dormant: ticks cause no violation until the lead state ends again.
- R10: A lead begin while armed, with no follow begin in that cycle, raises a violation.
- R11: `violation_o` stays 1 after it rises, whatever the inputs, until reset.
- R12: A lead end and a follow begin in the same cycle form a gap of zero, which is legal only when `MIN_TICKS` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| a_begin_i | input | 1 | Lead state begin pulse |
| a_finish_i | input | 1 | Lead state end pulse |
| b_begin_i | input | 1 | Follow state begin pulse |
| b_finish_i | input | 1 | Follow state end pulse |
| tick_i | input | 1 | Delay unit enable |
| violation_o | output | 1 | Sticky violation flag |

## Verification
Two cases can fall in the same cycle. In the first, the follow state begins on the very tick that closes or overruns the window, so the bound test and the timeout test both act at once. The bench puts a follow begin together with a tick when the count is just below `MAX_TICKS`, where it must pass, and again when the count equals `MAX_TICKS`, where it must fail. In the second, the lead end and the follow begin arrive together. This is judged against instances with zero and nonzero minimum. A behavioural model of the window is compared with four differently bounded instances on every clock.

// File: rtl/wprec_pkg.sv
package wprec_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_A_ON,
        ST_B_ON,
        ST_BOTH,
        ST_FAIL
    } wprec_state_e;

endpackage

// File: rtl/wprec_alt_check.sv
module wprec_alt_check (
    input  logic begin_i,
    input  logic finish_i,
    input  logic active_i,
    output logic err_o,
    output logic active_nxt_o
);

    always_comb begin
        err_o = 1'b0;
        if (begin_i && finish_i) begin
            err_o = 1'b1;
        end else if (begin_i && active_i) begin
            err_o = 1'b1;
        end else if (finish_i && !active_i) begin
            err_o = 1'b1;
        end
    end

    always_comb begin
        if (active_i) begin
            active_nxt_o = !finish_i;
        end else begin
            active_nxt_o = begin_i;
        end
    end

endmodule

// File: rtl/wprec_gap_window.sv
module wprec_gap_window #(
    parameter int CNT_W     = 8,
    parameter int MIN_TICKS = 2,
    parameter int MAX_TICKS = 5
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic clr_i,
    input  logic a_begin_i,
    input  logic a_finish_i,
    input  logic b_begin_i,
    input  logic tick_i,
    output logic armed_o,
    output logic orphan_o,
    output logic early_o,
    output logic late_o,
    output logic restart_o
);

    localparam logic [CNT_W-1:0] MIN_V   = MIN_TICKS[CNT_W-1:0];
    localparam logic [CNT_W-1:0] MAX_V   = MAX_TICKS[CNT_W-1:0];
    localparam logic [CNT_W-1:0] SAT_V   = {CNT_W{1'b1}};
    localparam bit               HAS_MAX = (MAX_TICKS != 0);
    localparam bit               HAS_MIN = (MIN_TICKS != 0);

    logic             armed_q;
    logic [CNT_W-1:0] gap_q;
    logic [CNT_W:0]   gap_eff;

    assign armed_o = armed_q;

    always_comb begin
        gap_eff = {1'b0, gap_q};
        if (tick_i && (gap_q != SAT_V)) begin
            gap_eff = {1'b0, gap_q} + {{CNT_W{1'b0}}, 1'b1};
        end
    end

    always_comb begin
        orphan_o  = b_begin_i && !armed_q && !a_finish_i;
        early_o   = 1'b0;
        if (b_begin_i && a_finish_i && HAS_MIN) begin
            early_o = 1'b1;
        end else if (b_begin_i && armed_q && (gap_eff < {1'b0, MIN_V})) begin
            early_o = 1'b1;
        end
        late_o    = HAS_MAX && armed_q && tick_i && (gap_q >= MAX_V);
        restart_o = a_begin_i && armed_q && !b_begin_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i) begin
            armed_q <= 1'b0;
            gap_q   <= '0;
        end else if (a_finish_i && !b_begin_i) begin
            armed_q <= 1'b1;
            gap_q   <= '0;
        end else if (b_begin_i || a_begin_i) begin
            armed_q <= 1'b0;
            gap_q   <= '0;
        end else if (armed_q && tick_i && (gap_q != SAT_V)) begin
            gap_q <= gap_q + {{(CNT_W-1){1'b0}}, 1'b1};
        end
    end

    generate
        if (HAS_MAX) begin : g_bounded
            a_r6_gap_in_bound: assert property (@(posedge clk_i) disable iff (rst_i)
                armed_q |-> (gap_q <= MAX_V));
        end
    endgenerate

    a_r4_arm_from_zero: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(armed_q) |-> (gap_q == '0));

endmodule

// File: rtl/wprec_checker.sv
module wprec_checker #(
    parameter int CNT_W     = 8,
    parameter int MIN_TICKS = 2,
    parameter int MAX_TICKS = 5
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic a_begin_i,
    input  logic a_finish_i,
    input  logic b_begin_i,
    input  logic b_finish_i,
    input  logic tick_i,
    output logic violation_o
);

    import wprec_pkg::*;

    wprec_state_e state_q;
    wprec_state_e state_d;

    logic a_act, b_act;
    logic a_err, b_err;
    logic a_nxt, b_nxt;
    logic armed, orphan, early, late, restart;
    logic fault;
    logic in_fail;

    always_comb begin
        a_act = (state_q == ST_A_ON) || (state_q == ST_BOTH);
        b_act = (state_q == ST_B_ON) || (state_q == ST_BOTH);
    end

    wprec_alt_check u_alt_a (
        .begin_i      (a_begin_i),
        .finish_i     (a_finish_i),
        .active_i     (a_act),
        .err_o        (a_err),
        .active_nxt_o (a_nxt)
    );

    wprec_alt_check u_alt_b (
        .begin_i      (b_begin_i),
        .finish_i     (b_finish_i),
        .active_i     (b_act),
        .err_o        (b_err),
        .active_nxt_o (b_nxt)
    );

    wprec_gap_window #(
        .CNT_W     (CNT_W),
        .MIN_TICKS (MIN_TICKS),
        .MAX_TICKS (MAX_TICKS)
    ) u_gap (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .clr_i      (fault || in_fail),
        .a_begin_i  (a_begin_i),
        .a_finish_i (a_finish_i),
        .b_begin_i  (b_begin_i),
        .tick_i     (tick_i),
        .armed_o    (armed),
        .orphan_o   (orphan),
        .early_o    (early),
        .late_o     (late),
        .restart_o  (restart)
    );

    assign fault   = a_err || b_err || orphan || early || late || restart;
    assign in_fail = (state_q == ST_FAIL);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_A_ON, ST_B_ON, ST_BOTH: begin
                if (fault) begin
                    state_d = ST_FAIL;
                end else if (a_nxt && b_nxt) begin
                    state_d = ST_BOTH;
                end else if (a_nxt) begin
                    state_d = ST_A_ON;
                end else if (b_nxt) begin
                    state_d = ST_B_ON;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_FAIL: begin
                state_d = ST_FAIL;
            end
            default: begin
                state_d = ST_FAIL;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        violation_o = in_fail;
    end

    a_r1_clear_after_reset: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> !violation_o);

    a_r2_same_cycle_pair: assert property (@(posedge clk_i) disable iff (rst_i)
        (a_begin_i && a_finish_i) |=> violation_o);

    a_r3_unarmed_follow: assert property (@(posedge clk_i) disable iff (rst_i)
        (b_begin_i && !armed && !a_finish_i) |=> violation_o);

    a_r11_sticky_flag: assert property (@(posedge clk_i) disable iff (rst_i)
        violation_o |=> violation_o);

endmodule

// File: tb/wprec_checker_bench.sv
module wprec_checker_bench;

    localparam int NI = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic a_s = 1'b0, a_e = 1'b0, b_s = 1'b0, b_e = 1'b0, tk = 1'b0;
    logic [NI-1:0] v;

    int lo [NI] = '{2, 3, 3, 0};
    int hi [NI] = '{5, 0, 3, 3};

    int  m_cnt   [NI];
    bit  m_armed [NI];
    bit  m_aon   [NI];
    bit  m_bon   [NI];
    bit  m_viol  [NI];

    int    checks = 0;
    int    fails  = 0;
    int    cycles = 0;
    bit    done   = 1'b0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    wprec_checker u_wprec_checker (
        .clk_i(clk), .rst_i(rst), .a_begin_i(a_s), .a_finish_i(a_e),
        .b_begin_i(b_s), .b_finish_i(b_e), .tick_i(tk), .violation_o(v[0]));

    wprec_checker #(.CNT_W(8), .MIN_TICKS(3), .MAX_TICKS(0)) u_wprec_checker_open (
        .clk_i(clk), .rst_i(rst), .a_begin_i(a_s), .a_finish_i(a_e),
        .b_begin_i(b_s), .b_finish_i(b_e), .tick_i(tk), .violation_o(v[1]));

    wprec_checker #(.CNT_W(8), .MIN_TICKS(3), .MAX_TICKS(3)) u_wprec_checker_exact (
        .clk_i(clk), .rst_i(rst), .a_begin_i(a_s), .a_finish_i(a_e),
        .b_begin_i(b_s), .b_finish_i(b_e), .tick_i(tk), .violation_o(v[2]));

    wprec_checker #(.CNT_W(8), .MIN_TICKS(0), .MAX_TICKS(3)) u_wprec_checker_upto (
        .clk_i(clk), .rst_i(rst), .a_begin_i(a_s), .a_finish_i(a_e),
        .b_begin_i(b_s), .b_finish_i(b_e), .tick_i(tk), .violation_o(v[3]));

    // behavioural reference, compared on every clock
    always @(posedge clk) begin
        for (int i = 0; i < NI; i++) begin
            if (rst) begin
                m_cnt[i] = 0; m_armed[i] = 0; m_aon[i] = 0; m_bon[i] = 0; m_viol[i] = 0;
            end else if (!m_viol[i]) begin
                bit bad;
                int gap;
                bad = 0;
                if (a_s && a_e) bad = 1;
                if (a_s && m_aon[i]) bad = 1;
                if (a_e && !m_aon[i]) bad = 1;
                if (b_s && b_e) bad = 1;
                if (b_s && m_bon[i]) bad = 1;
                if (b_e && !m_bon[i]) bad = 1;
                gap = m_cnt[i] + (tk ? 1 : 0);
                if (gap > 255) gap = 255;
                if (b_s) begin
                    if (a_e) begin
                        if (lo[i] != 0) bad = 1;
                    end else if (!m_armed[i]) begin
                        bad = 1;
                    end else if (gap < lo[i]) begin
                        bad = 1;
                    end
                end
                if (m_armed[i] && tk && hi[i] != 0 && m_cnt[i] + 1 > hi[i]) bad = 1;
                if (a_s && m_armed[i] && !b_s) bad = 1;
                if (bad) begin
                    m_viol[i] = 1;
                end else begin
                    if (a_s) m_aon[i] = 1;
                    if (a_e) m_aon[i] = 0;
                    if (b_s) m_bon[i] = 1;
                    if (b_e) m_bon[i] = 0;
                    if (a_e && !b_s) begin
                        m_armed[i] = 1; m_cnt[i] = 0;
                    end else if (b_s || a_s) begin
                        m_armed[i] = 0; m_cnt[i] = 0;
                    end else if (m_armed[i] && tk && m_cnt[i] < 255) begin
                        m_cnt[i]++;
                    end
                end
            end
        end
        #2;
        for (int i = 0; i < NI; i++) begin
            checks++;
            if (v[i] !== m_viol[i]) begin
                fails++;
                $display("FAIL %s instance %0d actual %0b expected %0b at cycle %0d",
                         cur_req, i, v[i], m_viol[i], cycles);
            end
        end
    end

    task automatic summary();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual %0d cycles expected completion", cycles);
            summary();
        end
    end

    task automatic cyc(input bit as, input bit ae, input bit bs, input bit be, input bit t);
        @(negedge clk);
        a_s = as; a_e = ae; b_s = bs; b_e = be; tk = t;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, 0);
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, 1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; a_s = 0; a_e = 0; b_s = 0; b_e = 0; tk = 0;
        idle(2);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // lead on, lead off, n ticks, then follow begin with or without a tick
    task automatic gap_seq(input int n, input bit tick_on_b);
        cyc(1, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 1);
        cyc(0, 1, 0, 0, 1);
        ticks(n);
        cyc(0, 0, 1, 0, tick_on_b);
        idle(2);
        cyc(0, 0, 0, 1, 0);
        idle(2);
    endtask

    initial begin
        // R1: reset state
        cur_req = "R1";
        do_reset();
        idle(1);
        @(posedge clk); #5;
        checks++;
        if (v !== '0) begin
            fails++;
            $display("FAIL R1 actual %b expected 0000", v);
        end

        // R4: gaps inside windows, tick on follow begin counted
        cur_req = "R4";
        for (int g = 0; g <= 6; g++) begin
            do_reset(); gap_seq(g, 1'b0);
            do_reset(); gap_seq(g, 1'b1);
        end

        // R5: below minimum
        cur_req = "R5";
        do_reset(); gap_seq(1, 1'b0);

        // R6: overrun on the closing tick, with and without follow begin
        cur_req = "R6";
        do_reset(); cyc(1, 0, 0, 0, 0); cyc(0, 1, 0, 0, 0); ticks(8); idle(2);
        do_reset(); gap_seq(4, 1'b1);
        do_reset(); gap_seq(5, 1'b1);
        do_reset(); gap_seq(3, 1'b1);

        // R7: open upper bound, counter saturation
        cur_req = "R7";
        do_reset(); gap_seq(300, 1'b1);

        // R8: exact window
        cur_req = "R8";
        do_reset(); gap_seq(3, 1'b0);
        do_reset(); gap_seq(2, 1'b0);
        do_reset(); gap_seq(4, 1'b0);

        // R9: dormant after correct follow begin
        cur_req = "R9";
        do_reset(); gap_seq(3, 1'b0); ticks(12); idle(1);

        // R3: unarmed follow begins
        cur_req = "R3";
        do_reset(); cyc(0, 0, 1, 0, 0); idle(2);
        do_reset(); cyc(1, 0, 0, 0, 0); ticks(3); cyc(0, 0, 1, 0, 1); idle(2);
        do_reset(); gap_seq(3, 1'b0); cyc(0, 0, 1, 0, 0); idle(2);

        // R10: lead restarts while waiting
        cur_req = "R10";
        do_reset(); cyc(1, 0, 0, 0, 0); cyc(0, 1, 0, 0, 0); ticks(1); cyc(1, 0, 0, 0, 0); idle(2);
        do_reset(); cyc(1, 0, 0, 0, 0); cyc(0, 1, 0, 0, 0); ticks(2); cyc(1, 0, 1, 0, 1); idle(2);

        // R12: zero gap
        cur_req = "R12";
        do_reset(); cyc(1, 0, 0, 0, 0); cyc(0, 1, 1, 0, 0); idle(2); cyc(0, 0, 0, 1, 0); idle(2);

        // R2: alternation integrity
        cur_req = "R2";
        do_reset(); cyc(1, 1, 0, 0, 0); idle(2);
        do_reset(); cyc(1, 0, 0, 0, 0); cyc(1, 0, 0, 0, 0); idle(2);
        do_reset(); cyc(0, 1, 0, 0, 0); idle(2);
        do_reset(); cyc(0, 0, 0, 1, 0); idle(2);
        do_reset(); gap_seq(3, 1'b0); cyc(1, 0, 0, 0, 0); cyc(0, 0, 0, 1, 0); idle(2);

        // R11: sticky after violation
        cur_req = "R11";
        do_reset(); cyc(0, 0, 1, 0, 0); gap_seq(3, 1'b0); ticks(20); idle(3);

        idle(2);
        summary();
    end

endmodule